// File: doc/BRIEF.md
# UART Status Flags and Interrupt Request

This block keeps the eight status flags of a serial port and merges them into one interrupt request. The transmit and receive datapaths send it single-cycle event pulses: a byte loaded into the transmit shifter, a character finished (with a qualifier marking break or preamble characters), a received byte placed in the data register, an idle line, and the four receive error conditions (overrun, noise, framing, parity). Each pulse sets its flag one clock later. The flags are presented as a status byte, and four enable inputs select which flags can raise the interrupt.

Software clears flags with a two-step sequence. A status-register access arms a one-bit latch. A later data-register access consumes the armed latch and clears one group of flags: a data write clears the two transmit flags, and a data read clears the six receive-side flags. A data access that finds the latch disarmed has no effect. The idle flag also has a re-arm rule: once it has been set, it cannot be set again until a new byte has been received.

The asynchronous active-low reset is released through a two-stage synchronizer. The first clock edge at which the flags can change is therefore the third rising edge after `rst_n` goes high.

Top module: `uart_flag_ctl`

## Requirements
- R1: After reset the status byte reads 0xC0 (transmit-empty and transmit-complete set, all others clear) and the interrupt output follows only the enabled flags.
- R2: Bit positions in the status byte are transmit-empty 7, transmit-complete 6, receive-ready 5, idle 4, overrun 3, noise 2, framing error 1, parity error 0. Each event pulse sets its bit at the next rising edge.
- R3: A data read or data write with no status access since the last completed sequence leaves every flag unchanged.
- R4: A status access followed by a data write clears bits 7 and 6 and leaves bits 5 to 0 unchanged.
- R5: A status access followed by a data read clears bits 5 to 0 and leaves bits 7 and 6 unchanged.
- R6: A data access that completes a sequence disarms it, so a second data access without a new status access clears nothing.
- R7: A character-finished pulse with the break/preamble qualifier high does not set transmit-complete. Without the qualifier it does set it.
- R8: After the idle flag has been set, further idle pulses are ignored until a received-byte pulse arrives. An idle pulse in that same cycle or later sets the flag again.
- R9: When a set pulse and a completing clear hit the same flag in one cycle, the flag ends up set.
- R10: The interrupt output is high exactly when transmit-empty and its enable are both set, or transmit-complete and its enable, or receive-ready or overrun together with the receive enable, or idle and its enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_tx_load | input | 1 | Transmit byte moved into shifter |
| ev_tx_done | input | 1 | Character transmission finished |
| ev_tx_special | input | 1 | Qualifies ev_tx_done as a break or preamble character |
| ev_rx_load | input | 1 | Received byte placed in data register |
| ev_idle | input | 1 | Idle line detected |
| ev_overrun | input | 1 | Receive overrun |
| ev_noise | input | 1 | Noise detected on a received character |
| ev_frame | input | 1 | Framing error |
| ev_parity | input | 1 | Parity error |
| sr_acc | input | 1 | Status register access strobe |
| dr_rd | input | 1 | Data register read strobe |
| dr_wr | input | 1 | Data register write strobe |
| en_txe | input | 1 | Interrupt enable for transmit-empty |
| en_txc | input | 1 | Interrupt enable for transmit-complete |
| en_rx | input | 1 | Interrupt enable for receive-ready and overrun |
| en_idle | input | 1 | Interrupt enable for idle |
| status_o | output | 8 | Status byte |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume that every event and bus strobe is a clean single-cycle pulse that is low while the internal reset is held. They also assume that the break/preamble qualifier only has meaning in a cycle where a character finishes. The stimulus drives every pulse for exactly one clock, and it starts only after the synchronized reset has been released. Several strobes may share a cycle only when a test deliberately pairs a set event with a completing clear.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;
  localparam int unsigned FLAG_W = 8;

  localparam int unsigned B_TXE   = 7;
  localparam int unsigned B_TXC   = 6;
  localparam int unsigned B_RXNE  = 5;
  localparam int unsigned B_IDLE  = 4;
  localparam int unsigned B_OVR   = 3;
  localparam int unsigned B_NOISE = 2;
  localparam int unsigned B_FRAME = 1;
  localparam int unsigned B_PAR   = 0;

  typedef logic [FLAG_W-1:0] flag_vec_t;

  // value of the status byte after reset
  localparam flag_vec_t FLAG_RST    = 8'hC0;
  // flags cleared by the write-ended sequence; the rest use the read-ended one
  localparam flag_vec_t WR_CLR_MASK = 8'hC0;
endpackage

// File: rtl/ufc_flag_bit.sv
module ufc_flag_bit #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q, q_d, q_en;

  // set has priority so that no event is lost
  always_comb begin
    q_en = set_i | clr_i;
    q_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_q <= RST_VAL;
    else if (q_en) q_q <= q_d;
  end

  assign q_o = q_q;

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
endmodule

// File: rtl/ufc_clear_seq.sv
module ufc_clear_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic sr_acc_i,
  input  logic dr_rd_i,
  input  logic dr_wr_i,
  output logic rd_clr_o,
  output logic wr_clr_o,
  output logic armed_o
);
  logic armed_q, armed_d, armed_en, dr_any;

  always_comb begin
    dr_any   = dr_rd_i | dr_wr_i;
    armed_en = sr_acc_i | dr_any;
    // a status access arms; a data access consumes the arming
    armed_d  = sr_acc_i | (armed_q & ~dr_any);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed_q <= 1'b0;
    else if (armed_en) armed_q <= armed_d;
  end

  assign rd_clr_o = armed_q & dr_rd_i;
  assign wr_clr_o = armed_q & dr_wr_i;
  assign armed_o  = armed_q;

  // R6: one data access disarms the sequence
  a_r6_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_any && !sr_acc_i) |=> !armed_o);
  a_r6_arm: assert property (@(posedge clk) disable iff (!rst_n)
    sr_acc_i |=> armed_o);
endmodule

// File: rtl/ufc_idle_gate.sv
module ufc_idle_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_load_i,
  input  logic idle_set_i,
  output logic allow_o
);
  logic allow_q, allow_d, allow_en;

  always_comb begin
    allow_en = rx_load_i | idle_set_i;
    allow_d  = rx_load_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        allow_q <= 1'b1;
    else if (allow_en) allow_q <= allow_d;
  end

  assign allow_o = allow_q;

  // R8: a new received byte always reopens the gate
  a_r8_reopen: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load_i |=> allow_o);
endmodule

// File: rtl/uart_flag_ctl.sv
module uart_flag_ctl
  import uart_flag_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_tx_load,
  input  logic       ev_tx_done,
  input  logic       ev_tx_special,
  input  logic       ev_rx_load,
  input  logic       ev_idle,
  input  logic       ev_overrun,
  input  logic       ev_noise,
  input  logic       ev_frame,
  input  logic       ev_parity,
  input  logic       sr_acc,
  input  logic       dr_rd,
  input  logic       dr_wr,
  input  logic       en_txe,
  input  logic       en_txc,
  input  logic       en_rx,
  input  logic       en_idle,
  output logic [7:0] status_o,
  output logic       irq_o
);
  // asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q = rs_q[1];

  logic rd_clr, wr_clr, armed;
  logic idle_allow, idle_fire;
  flag_vec_t set_vec, clr_vec, flag_q;

  ufc_clear_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_q),
    .sr_acc_i (sr_acc),
    .dr_rd_i  (dr_rd),
    .dr_wr_i  (dr_wr),
    .rd_clr_o (rd_clr),
    .wr_clr_o (wr_clr),
    .armed_o  (armed)
  );

  assign idle_fire = ev_idle & (idle_allow | ev_rx_load);

  ufc_idle_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_q),
    .rx_load_i  (ev_rx_load),
    .idle_set_i (idle_fire),
    .allow_o    (idle_allow)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[B_TXE]   = ev_tx_load;
    set_vec[B_TXC]   = ev_tx_done & ~ev_tx_special;
    set_vec[B_RXNE]  = ev_rx_load;
    set_vec[B_IDLE]  = idle_fire;
    set_vec[B_OVR]   = ev_overrun;
    set_vec[B_NOISE] = ev_noise;
    set_vec[B_FRAME] = ev_frame;
    set_vec[B_PAR]   = ev_parity;
  end

  for (genvar g = 0; g < FLAG_W; g++) begin : g_flag
    if (WR_CLR_MASK[g]) begin : g_wr
      assign clr_vec[g] = wr_clr;
    end else begin : g_rd
      assign clr_vec[g] = rd_clr;
    end

    ufc_flag_bit #(.RST_VAL(FLAG_RST[g])) u_bit (
      .clk   (clk),
      .rst_n (rst_q),
      .set_i (set_vec[g]),
      .clr_i (clr_vec[g]),
      .q_o   (flag_q[g])
    );
  end

  assign status_o = flag_q;

  always_comb begin
    irq_o = (flag_q[B_TXE]  & en_txe)
          | (flag_q[B_TXC]  & en_txc)
          | ((flag_q[B_RXNE] | flag_q[B_OVR]) & en_rx)
          | (flag_q[B_IDLE] & en_idle);
  end

  // R3: with the sequence disarmed a set flag cannot drop
  a_r3_rxne_hold: assert property (@(posedge clk) disable iff (!rst_q)
    (status_o[5] && !armed) |=> status_o[5]);
  a_r3_txe_hold: assert property (@(posedge clk) disable iff (!rst_q)
    (status_o[7] && !armed) |=> status_o[7]);
  // R7: a break/preamble completion never raises transmit-complete
  a_r7_special_no_tc: assert property (@(posedge clk) disable iff (!rst_q)
    (!status_o[6] && ev_tx_special) |=> !status_o[6]);
  // R8: idle stays low while the gate is closed and no byte arrives
  a_r8_idle_blocked: assert property (@(posedge clk) disable iff (!rst_q)
    (!idle_allow && !ev_rx_load && !status_o[4]) |=> !status_o[4]);
  // R10: no flag set means no request
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_q)
    (status_o == 8'h00) |-> !irq_o);
  a_r10_rx_irq: assert property (@(posedge clk) disable iff (!rst_q)
    (status_o[3] && en_rx) |-> irq_o);
endmodule

// File: tb/uart_flag_ctl_bench.sv
module uart_flag_ctl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_tx_load = 0, ev_tx_done = 0, ev_tx_special = 0, ev_rx_load = 0;
  logic ev_idle = 0, ev_overrun = 0, ev_noise = 0, ev_frame = 0, ev_parity = 0;
  logic sr_acc = 0, dr_rd = 0, dr_wr = 0;
  logic en_txe = 0, en_txc = 0, en_rx = 0, en_idle = 0;
  logic [7:0] status_o;
  logic irq_o;

  always #4 clk = ~clk; // 125 MHz

  uart_flag_ctl u_uart_flag_ctl (
    .clk(clk), .rst_n(rst_n),
    .ev_tx_load(ev_tx_load), .ev_tx_done(ev_tx_done), .ev_tx_special(ev_tx_special),
    .ev_rx_load(ev_rx_load), .ev_idle(ev_idle), .ev_overrun(ev_overrun),
    .ev_noise(ev_noise), .ev_frame(ev_frame), .ev_parity(ev_parity),
    .sr_acc(sr_acc), .dr_rd(dr_rd), .dr_wr(dr_wr),
    .en_txe(en_txe), .en_txc(en_txc), .en_rx(en_rx), .en_idle(en_idle),
    .status_o(status_o), .irq_o(irq_o)
  );

  localparam logic [11:0] P_NONE = 12'h000, P_SR = 12'h800, P_DRR = 12'h400,
    P_DRW = 12'h200, P_TXL = 12'h100, P_TXD = 12'h080, P_TXS = 12'h040,
    P_RXL = 12'h020, P_IDL = 12'h010, P_OVR = 12'h008, P_NOI = 12'h004,
    P_FRM = 12'h002, P_PAR = 12'h001;

  typedef struct {
    logic [7:0] st;
    logic       irq;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int total = 0;
  int bad = 0;
  bit done = 0;

  // monitor: compares each expectation as soon as it is queued
  initial begin
    forever begin
      wait (exp_q.size() != 0);
      begin
        exp_t e;
        e = exp_q.pop_front();
        total++;
        if (status_o !== e.st || irq_o !== e.irq) begin
          bad++;
          $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
                   e.tag, status_o, irq_o, e.st, e.irq);
        end
      end
    end
  end

  // driver: one-cycle pulses driven after negedge, result expected after the edge
  task automatic step(input logic [11:0] p, input logic [7:0] es,
                      input logic ei, input string tag);
    exp_t e;
    @(negedge clk);
    {sr_acc, dr_rd, dr_wr, ev_tx_load, ev_tx_done, ev_tx_special,
     ev_rx_load, ev_idle, ev_overrun, ev_noise, ev_frame, ev_parity} = p;
    @(posedge clk);
    #2;
    {sr_acc, dr_rd, dr_wr, ev_tx_load, ev_tx_done, ev_tx_special,
     ev_rx_load, ev_idle, ev_overrun, ev_noise, ev_frame, ev_parity} = '0;
    e.st = es; e.irq = ei; e.tag = tag;
    exp_q.push_back(e);
    #1;
  endtask

  task automatic finish_run();
    wait (exp_q.size() == 0);
    #1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    step(P_NONE, 8'hC0, 1'b0, "R1 reset value");
    en_txe = 1;
    step(P_NONE, 8'hC0, 1'b1, "R1 R10 txe enabled raises irq");
    en_txe = 0; en_txc = 1;
    step(P_NONE, 8'hC0, 1'b1, "R10 txc enabled raises irq");
    en_txc = 0;
    // R3 unarmed accesses
    step(P_DRW, 8'hC0, 1'b0, "R3 write without status access");
    step(P_DRR, 8'hC0, 1'b0, "R3 read without status access");
    // R4
    step(P_SR, 8'hC0, 1'b0, "R4 status access arms");
    step(P_DRW, 8'h00, 1'b0, "R4 write clears tx flags");
    step(P_TXL, 8'h80, 1'b0, "R2 tx load sets bit 7");
    // R5 / R6
    step(P_SR, 8'h80, 1'b0, "R5 status access");
    step(P_DRR, 8'h80, 1'b0, "R5 read keeps tx flags");
    step(P_DRW, 8'h80, 1'b0, "R6 second access does not clear");
    // R7
    step(P_TXD | P_TXS, 8'h80, 1'b0, "R7 special done keeps tc clear");
    step(P_TXD, 8'hC0, 1'b0, "R7 normal done sets bit 6");
    // R2 receive-side bits
    step(P_RXL, 8'hE0, 1'b0, "R2 rx load sets bit 5");
    step(P_OVR, 8'hE8, 1'b0, "R2 overrun sets bit 3");
    step(P_NOI, 8'hEC, 1'b0, "R2 noise sets bit 2");
    step(P_FRM, 8'hEE, 1'b0, "R2 framing sets bit 1");
    step(P_PAR, 8'hEF, 1'b0, "R2 parity sets bit 0");
    step(P_SR, 8'hEF, 1'b0, "R4 arm");
    step(P_DRW, 8'h2F, 1'b0, "R4 write clears only bits 7 6");
    step(P_SR, 8'h2F, 1'b0, "R5 arm");
    step(P_DRR, 8'h00, 1'b0, "R5 read clears bits 5 to 0");
    // R8 idle re-arm
    step(P_IDL, 8'h10, 1'b0, "R2 idle sets bit 4");
    en_idle = 1;
    step(P_NONE, 8'h10, 1'b1, "R10 idle enabled raises irq");
    en_idle = 0;
    step(P_SR, 8'h10, 1'b0, "R8 arm");
    step(P_DRR, 8'h00, 1'b0, "R8 read clears idle");
    step(P_IDL, 8'h00, 1'b0, "R8 idle ignored before new byte");
    step(P_RXL, 8'h20, 1'b0, "R8 new byte received");
    step(P_IDL, 8'h30, 1'b0, "R8 idle accepted after new byte");
    // R9 set beats clear
    step(P_SR, 8'h30, 1'b0, "R9 arm");
    en_rx = 1;
    step(P_DRR | P_OVR, 8'h08, 1'b1, "R9 R10 overrun set during read clear");
    en_rx = 0;
    step(P_NONE, 8'h08, 1'b0, "R10 rx enable low masks overrun");
    step(P_SR, 8'h08, 1'b0, "R9 arm for write");
    step(P_DRW | P_TXL, 8'h88, 1'b0, "R9 tx load during write clear");
    done = 1;
    finish_run();
  end
endmodule